// File: doc/BRIEF.md
# Speculative Hold and Trigger-Acceptance Controller

This block drives the hold line that freezes the sample capacitors of a multi-channel front end. The shaping of the front end is faster than the final trigger decision, so the controller reacts to a fast early trigger (the pretrigger) by asserting hold at once. It then opens an acceptance window of a fixed number of clock cycles and waits for the slower level-1 decision. When level-1 arrives inside the window, hold is kept, a one-cycle readout request goes to the scan sequencer, and hold is released only when the sequencer reports that the scan is complete. When the window runs out without level-1, hold is dropped and the controller accepts a new pretrigger in the very next cycle.

A test-mode input keeps the channels tracking: while it is high, no pretrigger takes effect. If test mode is raised during a hold, the hold is abandoned. The window length is a parameter in clock cycles (120 cycles gives 1.2 µs at 100 MHz).

Top module: `hold_ctl`

## Requirements
- R1: After reset, hold_o, rdo_start_o and busy_o are all low.
- R2: With test_mode_i low and hold_o low, a pretrig_i sampled high on a clock edge makes hold_o high from that edge on, with busy_o still low.
- R3: If no lvl1_i is sampled while waiting, hold_o stays high for exactly WIN_CYCLES cycles after the pretrigger edge and then drops.
- R4: A lvl1_i sampled high while waiting (including on the last window cycle) keeps hold_o high, raises busy_o, and pulses rdo_start_o high for exactly one cycle, all starting on that edge.
- R5: A lvl1_i that is sampled high on the same edge that would end the window is accepted as a level-1 (R4), not as a timeout.
- R6: After a timeout, a pretrig_i sampled on the first cycle with hold_o low is accepted (no dead time).
- R7: During readout (busy_o high), hold_o stays high until scan_done_i is sampled high; on that edge hold_o and busy_o both go low.
- R8: A pretrig_i sampled while waiting or reading out has no effect: it neither restarts the window nor starts a second readout.
- R9: A lvl1_i sampled while idle, and a scan_done_i sampled while idle or waiting, have no effect on any output.
- R10: While test_mode_i is high, pretrig_i is ignored; if test_mode_i is sampled high while hold_o is high, hold_o and busy_o drop on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pretrig_i | input | 1 | Early trigger, one or more cycles high |
| lvl1_i | input | 1 | Final trigger decision |
| scan_done_i | input | 1 | Scan sequencer has finished reading all channels |
| test_mode_i | input | 1 | Keep channels tracking; hold suppressed |
| hold_o | output | 1 | Hold line to the sample capacitors |
| rdo_start_o | output | 1 | One-cycle request to start the channel scan |
| busy_o | output | 1 | Readout in progress |

## Verification
The two functions that can land on one cycle are the window timeout and level-1 acceptance: the bench raises lvl1_i exactly on the final window cycle, and the design is judged correct only if hold_o stays high and rdo_start_o pulses on that edge instead of hold falling. A second collision, a repeated pretrigger inside the window, is checked by confirming that hold_o still falls exactly WIN_CYCLES cycles after the first pretrigger edge. Test mode arriving together with a pending hold is judged by hold_o falling on that same edge.

// File: rtl/hold_ctl_pkg.sv
package hold_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_READ = 2'd2
    } hc_state_e;

    typedef struct packed {
        hc_state_e state;
        logic      start;
    } hc_regs_t;

endpackage

// File: rtl/hold_win_timer.sv
module hold_win_timer #(
    parameter int unsigned WIN_CYCLES = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic last_o
);
    localparam int unsigned CW = (WIN_CYCLES < 2) ? 1 : $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && (cnt_q != LAST_VAL)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/hold_seq_fsm.sv
module hold_seq_fsm
    import hold_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pretrig_i,
    input  logic lvl1_i,
    input  logic scan_done_i,
    input  logic test_mode_i,
    input  logic win_last_i,
    output logic tmr_clr_o,
    output logic tmr_en_o,
    output logic hold_o,
    output logic start_o,
    output logic busy_o
);
    hc_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (pretrig_i && !test_mode_i) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (test_mode_i) begin
                    r_d.state = ST_IDLE;
                end else if (lvl1_i) begin
                    r_d.state = ST_READ;
                    r_d.start = 1'b1;
                end else if (win_last_i) begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_READ: begin
                if (test_mode_i || scan_done_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.start <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tmr_clr_o = (r_q.state != ST_WAIT);
    assign tmr_en_o  = (r_q.state == ST_WAIT);
    assign hold_o    = (r_q.state != ST_IDLE);
    assign busy_o    = (r_q.state == ST_READ);
    assign start_o   = r_q.start;

endmodule

// File: rtl/hold_ctl.sv
module hold_ctl #(
    parameter int unsigned WIN_CYCLES = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pretrig_i,
    input  logic lvl1_i,
    input  logic scan_done_i,
    input  logic test_mode_i,
    output logic hold_o,
    output logic rdo_start_o,
    output logic busy_o
);
    logic tmr_clr, tmr_en, win_last;

    hold_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .en_i   (tmr_en),
        .last_o (win_last)
    );

    hold_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pretrig_i   (pretrig_i),
        .lvl1_i      (lvl1_i),
        .scan_done_i (scan_done_i),
        .test_mode_i (test_mode_i),
        .win_last_i  (win_last),
        .tmr_clr_o   (tmr_clr),
        .tmr_en_o    (tmr_en),
        .hold_o      (hold_o),
        .start_o     (rdo_start_o),
        .busy_o      (busy_o)
    );

endmodule

// File: rtl/hold_ctl_chk.sv
module hold_ctl_chk #(
    parameter int unsigned WIN_CYCLES = 120
) (
    input logic clk,
    input logic rst_n,
    input logic pretrig_i,
    input logic lvl1_i,
    input logic scan_done_i,
    input logic test_mode_i,
    input logic hold_o,
    input logic rdo_start_o,
    input logic busy_o
);
    localparam int unsigned CW = $clog2(WIN_CYCLES + 2);

    logic [CW-1:0] wait_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wait_cnt <= '0;
        else if (hold_o && !busy_o) wait_cnt <= wait_cnt + CW'(1);
        else                        wait_cnt <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!hold_o && !busy_o && !rdo_start_o));

    assert_pretrig_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pretrig_i && !test_mode_i && !hold_o) |=> (hold_o && !busy_o));

    assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !busy_o) |-> (wait_cnt < CW'(WIN_CYCLES)));

    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !busy_o && lvl1_i && !test_mode_i) |=> (busy_o && rdo_start_o));

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rdo_start_o |=> !rdo_start_o);

    assert_busy_under_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> hold_o);

    assert_read_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !scan_done_i && !test_mode_i) |=> busy_o);

    assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && scan_done_i) |=> !hold_o);

    assert_idle_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o |=> !busy_o);

    assert_test_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode_i |=> !hold_o);

endmodule

bind hold_ctl hold_ctl_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pretrig_i   (pretrig_i),
    .lvl1_i      (lvl1_i),
    .scan_done_i (scan_done_i),
    .test_mode_i (test_mode_i),
    .hold_o      (hold_o),
    .rdo_start_o (rdo_start_o),
    .busy_o      (busy_o)
);

// File: tb/tb_hold_ctl.sv
`timescale 1ns/1ps
module tb_hold_ctl;
    localparam int unsigned WIN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pre = 1'b0, l1 = 1'b0, done = 1'b0, tm = 1'b0;
    logic hold, start, busy;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hold_ctl #(.WIN_CYCLES(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .pretrig_i(pre), .lvl1_i(l1),
        .scan_done_i(done), .test_mode_i(tm),
        .hold_o(hold), .rdo_start_o(start), .busy_o(busy)
    );

    // vector: {pre, l1, done, tm, exp_hold, exp_start, exp_busy}
    localparam int NV = 12;
    localparam logic [6:0] VEC [NV] = '{
        7'b0000_000,  // idle stays quiet (R1)
        7'b0100_000,  // level-1 while idle ignored (R9)
        7'b1000_100,  // pretrigger -> hold (R2)
        7'b1000_100,  // repeated pretrigger ignored (R8)
        7'b0100_111,  // level-1 accepted (R4)
        7'b0000_101,  // readout continues, pulse ended (R4, R7)
        7'b1000_101,  // pretrigger during readout ignored (R8)
        7'b0010_000,  // scan done releases (R7)
        7'b1001_000,  // pretrigger under test mode ignored (R10)
        7'b0010_000,  // scan done while idle ignored (R9)
        7'b1000_100,  // pretrigger again (R2)
        7'b0001_000   // test mode aborts hold (R10)
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {hold,start,busy} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic p, input logic l, input logic d, input logic t);
        @(negedge clk);
        pre = p; l1 = l; done = d; tm = t;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {hold, start, busy}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            check($sformatf("vector %0d", i), {hold, start, busy}, VEC[i][2:0]);
        end

        // R3/R8: timeout after exactly WIN cycles despite a second pretrigger
        step(1, 0, 0, 0);
        check("R2 hold on pretrigger", {hold, start, busy}, 3'b100);
        for (int k = 1; k < int'(WIN); k++) begin
            step(k == 2, 0, k == 3, 0);
            check("R3 hold within window", {hold, start, busy}, 3'b100);
        end
        step(0, 0, 0, 0);
        check("R3 hold released at window end", {hold, start, busy}, 3'b000);

        // R6: no dead time
        step(1, 0, 0, 0);
        check("R6 immediate rearm", {hold, start, busy}, 3'b100);

        // R5: level-1 on the expiry cycle
        for (int k = 1; k < int'(WIN); k++) step(0, 0, 0, 0);
        step(0, 1, 0, 0);
        check("R5 level-1 on expiry accepted", {hold, start, busy}, 3'b111);
        step(0, 0, 0, 0);
        check("R7 hold during readout", {hold, start, busy}, 3'b101);
        step(0, 0, 1, 0);
        check("R7 release on done", {hold, start, busy}, 3'b000);

        // R9: level-1 one cycle after a timeout is ignored
        step(1, 0, 0, 0);
        for (int k = 1; k <= int'(WIN); k++) step(0, 0, 0, 0);
        check("R3 timeout", {hold, start, busy}, 3'b000);
        step(0, 1, 0, 0);
        check("R9 late level-1 ignored", {hold, start, busy}, 3'b000);

        // R1: reset in the middle of a readout
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset mid-readout", {hold, start, busy}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        check("R1 idle after reset", {hold, start, busy}, 3'b000);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule